// File: doc/BRIEF.md
# Chip-Enable-Latched Parallel Memory Controller

This block sits on the host side of an asynchronous byte-wide parallel memory. That memory captures its address only when the active-low chip enable goes low. The host offers one request at a time through a valid/ready handshake. Each request carries an address, write data and a direction flag. The controller turns each request into one complete chip-enable pulse: it presents the address for a set number of setup cycles, pulls chip enable low for the access window, and then holds chip enable high for a precharge interval before it accepts the next request.

On a read, output enable is held low while chip enable is low. The data bus is sampled in the last cycle of the access window and returned with a single-cycle done pulse. On a write, write enable is held low for the whole chip-enable-low window, so the write starts on the same edge that latches the address. The controller drives the data bus only for writes, only from setup through the end of the access, and never while output enable is low. All timing values are parameters counted in system clock cycles.

Top module: `ceLatchMemCtrl`

## Requirements
- R1: While reset is asserted, chip enable, output enable and write enable are all high (inactive), reqReady is high, rspDone is low and the controller does not drive memDq.
- R2: Every time chip enable falls, memAddr has held the accepted address for at least SETUP_CYC cycles with chip enable high. memAddr then stays unchanged for as long as chip enable stays low.
- R3: Each accepted request gives exactly one chip-enable-low pulse. The pulse lasts ACCESS_CYC cycles for a read and WRITE_CYC cycles for a write.
- R4: During a read pulse, output enable is low and write enable is high. memDq is captured in the last low cycle of chip enable. rspData shows the captured byte in the cycle when rspDone is high.
- R5: During a write pulse, write enable is low and output enable is high for every cycle. reqWdata is driven on memDq, so a later read of the same address returns it.
- R6: After each pulse, chip enable stays high for at least PRECHARGE_CYC cycles before the next request can be accepted. Together with setup, this gives a high gap of at least PRECHARGE_CYC+SETUP_CYC cycles between pulses. reqReady is low from acceptance until the precharge ends.
- R7: Output enable and write enable are never low together. The controller releases memDq (high impedance) whenever output enable is low and whenever it is idle.
- R8: rspDone is a single-cycle pulse. It is raised exactly once per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | DATA_W | Write data |
| rspData | output | DATA_W | Read data, valid with rspDone |
| rspDone | output | 1 | One-cycle read completion pulse |
| memAddr | output | ADDR_W | Memory address pins |
| memCeN | output | 1 | Memory chip enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memDq | inout | DATA_W | Bidirectional memory data bus |

## Verification
The assertions rely on the host holding reqWrite, reqAddr and reqWdata steady in the cycle where reqValid meets reqReady. They also rely on the memory driving memDq only while chip enable and output enable are both low and write enable is high. The bench meets both conditions. It changes the request fields only half a cycle away from the clock edge and withdraws reqValid right after acceptance. Its behavioural memory model drives the bus only under that strobe combination and takes its address from the chip-enable falling edge.

// File: rtl/ceMemPkg.sv
package ceMemPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_PRECH  = 2'd3
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // register the host request
    logic capture;  // sample memDq into the read register
    logic driveEn;  // drive write data onto memDq
  } memStrobe_t;

endpackage

// File: rtl/ceMemCtrl.sv
module ceMemCtrl
  import ceMemPkg::*;
#(
  parameter int SETUP_CYC     = 2,
  parameter int ACCESS_CYC    = 4,
  parameter int WRITE_CYC     = 3,
  parameter int PRECHARGE_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       memCeN,
  output logic       memOeN,
  output logic       memWeN,
  output memStrobe_t strobe
);

  localparam int MAX_A   = (ACCESS_CYC > WRITE_CYC) ? ACCESS_CYC : WRITE_CYC;
  localparam int MAX_B   = (SETUP_CYC > PRECHARGE_CYC) ? SETUP_CYC : PRECHARGE_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrlState_t state;
  logic [CNT_W-1:0] cnt;
  logic isWrite;
  logic accessLast;

  assign accessLast = isWrite ? (cnt == CNT_W'(WRITE_CYC - 1))
                              : (cnt == CNT_W'(ACCESS_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state   <= ST_SETUP;
          cnt     <= '0;
          isWrite <= reqWrite;
        end
        ST_SETUP: if (cnt == CNT_W'(SETUP_CYC - 1)) begin
          state <= ST_ACCESS;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_ACCESS: if (accessLast) begin
          state <= ST_PRECH;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_PRECH: if (cnt == CNT_W'(PRECHARGE_CYC - 1)) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady       = (state == ST_IDLE);
    memCeN         = (state != ST_ACCESS);
    memOeN         = !((state == ST_ACCESS) && !isWrite);
    memWeN         = !((state == ST_ACCESS) && isWrite);
    strobe.load    = (state == ST_IDLE) && reqValid;
    strobe.capture = (state == ST_ACCESS) && !isWrite && accessLast;
    strobe.driveEn = isWrite && ((state == ST_SETUP) || (state == ST_ACCESS));
  end

  // R7: the two active-low strobes never overlap
  a_r7_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  // R6: chip enable stays high for at least one cycle after it rises
  a_r6_precharge_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |=> memCeN);

  // R6: no acceptance while chip enable is low
  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> !reqReady);

  // R7: write data is never driven while output enable is low
  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    strobe.driveEn |-> memOeN);

endmodule

// File: rtl/ceMemDatapath.sv
module ceMemDatapath
  import ceMemPkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memDq,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      if (strobe.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.capture) rdataQ <= memDq;
      doneQ <= strobe.capture;
    end
  end

  assign memAddr = addrQ;
  assign memDq   = strobe.driveEn ? wdataQ : {DATA_W{1'bz}};
  assign rspData = rdataQ;
  assign rspDone = doneQ;

  // R8: done lasts exactly one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R4: read data register changes only together with a done pulse
  a_r4_data_with_done: assert property (@(posedge clk) disable iff (!rstN)
    !rspDone |-> $stable(rspData) || $past(!rstN));

endmodule

// File: rtl/ceLatchMemCtrl.sv
module ceLatchMemCtrl
  import ceMemPkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int SETUP_CYC     = 2,
  parameter int ACCESS_CYC    = 4,
  parameter int WRITE_CYC     = 3,
  parameter int PRECHARGE_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  inout  wire  [DATA_W-1:0] memDq
);

  memStrobe_t strobe;

  ceMemCtrl #(
    .SETUP_CYC    (SETUP_CYC),
    .ACCESS_CYC   (ACCESS_CYC),
    .WRITE_CYC    (WRITE_CYC),
    .PRECHARGE_CYC(PRECHARGE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .strobe  (strobe)
  );

  ceMemDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memAddr (memAddr),
    .memDq   (memDq),
    .rspData (rspData),
    .rspDone (rspDone)
  );

  // R2: address held for the whole chip-enable-low window
  a_r2_addr_stable_low: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R2: address already settled on the cycle chip enable falls
  a_r2_addr_before_fall: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memCeN) && $past(rstN)) |-> $stable(memAddr));

endmodule

// File: tb/ceLatchMemCtrl_bench.sv
module ceLatchMemCtrl_bench;

  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int SU  = 2;
  localparam int AC  = 3;
  localparam int WR  = 2;
  localparam int PRE = 2;
  localparam int NLOC = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspDone, memCeN, memOeN, memWeN;
  logic [DW-1:0] rspData;
  logic [AW-1:0] memAddr;
  wire  [DW-1:0] memDq;

  int checks = 0;
  int errors = 0;
  int readsIssued = 0;
  int donesSeen = 0;
  logic curIsWrite = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ceLatchMemCtrl #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .ACCESS_CYC(AC),
    .WRITE_CYC(WR), .PRECHARGE_CYC(PRE)
  ) u_ceLatchMemCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspData(rspData), .rspDone(rspDone), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memDq(memDq)
  );

  // behavioural memory: address latched on chip-enable falling edge
  logic [DW-1:0] mem [NLOC];
  logic [AW-1:0] latchedAddr = '0;
  always @(negedge memCeN) latchedAddr = memAddr;
  always @(posedge clk) if (!memCeN && !memWeN) mem[latchedAddr] <= memDq;
  assign memDq = (!memCeN && memWeN && !memOeN) ? mem[latchedAddr] : {DW{1'bz}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int pass);
    return DW'(a * 29 + pass * 71 + 3);
  endfunction

  // port monitor, sampled on the falling clock edge
  logic prevCe = 1'b1;
  logic [AW-1:0] prevAddr = '0;
  logic [AW-1:0] addrAtFall = '0;
  int addrRun = 0, highRun = 1000, lowRun = 0;
  always @(negedge clk) if (rstN) begin
    addrRun = (memAddr == prevAddr) ? addrRun + 1 : 1;
    if (rspDone) donesSeen++;
    if (prevCe && !memCeN) begin
      chk(addrRun >= SU + 1, "R2 setup", addrRun, SU + 1);
      chk(highRun >= PRE + SU, "R6 gap", highRun, PRE + SU);
      addrAtFall = memAddr;
      lowRun = 0;
    end
    if (!prevCe && memCeN)
      chk(lowRun == (curIsWrite ? WR : AC), "R3 pulse", lowRun, curIsWrite ? WR : AC);
    if (!memCeN) begin
      lowRun++;
      highRun = 0;
      chk(memAddr == addrAtFall, "R2 hold", memAddr, addrAtFall);
      chk(memWeN == !curIsWrite, curIsWrite ? "R5 we" : "R4 we", memWeN, !curIsWrite);
      chk(memOeN == curIsWrite, curIsWrite ? "R5 oe" : "R4 oe", memOeN, curIsWrite);
      chk(!reqReady, "R6 ready", reqReady, 0);
    end else highRun++;
    if (reqReady) chk(memDq === {DW{1'bz}}, "R7 idle release", memDq, 0);
    prevCe = memCeN;
    prevAddr = memAddr;
  end

  task automatic access(input bit wr, input int a, input logic [DW-1:0] d, input bit checkRd, input logic [DW-1:0] exp);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = AW'(a); reqWdata = d;
    curIsWrite = wr;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~reqAddr; reqWdata = ~reqWdata;
    if (!wr) begin
      readsIssued++;
      while (!rspDone) @(negedge clk);
      if (checkRd) chk(rspData == exp, "R4 data", rspData, exp);
      @(negedge clk);
      chk(!rspDone, "R8 single", rspDone, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(memCeN && memOeN && memWeN, "R1 strobes", {memCeN, memOeN, memWeN}, 7);
    chk(reqReady && !rspDone, "R1 handshake", {reqReady, rspDone}, 2);
    chk(memDq === {DW{1'bz}}, "R1 bus", memDq, 0);
    rstN = 1'b1;
    for (int a = 0; a < NLOC; a++) access(1'b1, a, pat(a, 0), 1'b0, '0);
    for (int a = NLOC - 1; a >= 0; a--) access(1'b0, a, '0, 1'b1, pat(a, 0)); // R5 readback
    for (int a = 0; a < NLOC; a += 7) begin
      access(1'b1, a, pat(a, 1), 1'b0, '0);
      access(1'b0, a, '0, 1'b1, pat(a, 1));
      access(1'b0, (a + 1) % NLOC, '0, 1'b1, pat((a + 1) % NLOC, 0));
    end
    repeat (PRE + 4) @(negedge clk);
    chk(donesSeen == readsIssued, "R8 count", donesSeen, readsIssued);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule